// File: doc/BRIEF.md
# Data Translation Buffer with Page Rights Checking

This block sits between a CPU's load/store unit and memory. It translates each data access from a virtual address to a physical one, using a small fully associative set of cached page mappings. Each mapping holds a virtual page tag, a physical frame number and two separate permission flags, one for loads and one for stores. A lookup happens in the same cycle as the request. A permitted hit returns the physical address together with a grant.

When the page is absent, the block raises a miss request. When the page is present but the needed permission is off, it raises a separate fault request. Either way it captures the faulting address, with the low two bits replaced by a code that tells the handler whether the access was a load or a store.

Software maintains the contents through a command port. A fill installs a mapping; a fill for a page already held rewrites that slot, and any other fill takes the next slot in rotation. A retune changes only the permission flags of a held page. It is meant for the case where a handler finds that a fault came from a stale entry. Software can also drop one page or flush all entries.

Top module: `dtlb_core`

## Requirements
- R1: A valid access that hits an entry holding the needed permission (read flag for loads, write flag for stores) raises `acc_grant_o` in the same cycle and drives `acc_paddr_o` = {frame number, `acc_vaddr_i[11:0]`}.
- R2: A load that hits an entry with the read flag clear gets no grant, and `exc_fault_o` is high for exactly the one cycle after the request edge, with `exc_miss_o` low.
- R3: A store that hits an entry with the write flag clear gets no grant, and `exc_fault_o` is high for exactly the one cycle after the request edge, with `exc_miss_o` low.
- R4: A valid access whose page is not held raises `exc_miss_o` for one cycle after the request edge and never `exc_fault_o`, whatever permissions are presented.
- R5: The edge that raises `exc_miss_o` or `exc_fault_o` also loads `exc_addr_o` = {`acc_vaddr_i[31:2]`, code}, where the code is 2'b01 for a load and 2'b10 for a store.
- R6: A fill (`sw_fill_i`) stores `sw_pfn_i`, `sw_rd_i` and `sw_wr_i` for page `sw_vpn_i`. If that page is already held, its slot is rewritten in place and the rotation pointer does not move.
- R7: A retune (`sw_retune_i`) replaces only the two permission flags of the held page `sw_vpn_i` and keeps its frame number. A retune for a page that is not held changes nothing.
- R8: There are 8 slots. Fills of new pages use slots 0,1,...,7 in rotation from reset, so the ninth new page evicts the first one filled.
- R9: A drop (`sw_drop_i`) removes only the page `sw_vpn_i`; every other page still hits.
- R10: A flush (`sw_flush_i`) removes every entry in one cycle.
- R11: In a cycle with `acc_valid_i` low, no exception is raised on the next cycle and `exc_addr_o` keeps its value.
- R12: After reset no page is held, and `acc_grant_o`, `exc_miss_o`, `exc_fault_o` and `exc_addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | Data access request valid |
| acc_write_i | input | 1 | 1 = store, 0 = load |
| acc_vaddr_i | input | 32 | Virtual address of the access |
| acc_grant_o | output | 1 | Hit with the needed permission |
| acc_paddr_o | output | 32 | Translated physical address (zero without a grant) |
| exc_miss_o | output | 1 | One-cycle translation miss request |
| exc_fault_o | output | 1 | One-cycle permission fault request |
| exc_addr_o | output | 32 | Captured faulting address with the access code in bits 1:0 |
| sw_flush_i | input | 1 | Remove all entries (highest command priority) |
| sw_drop_i | input | 1 | Remove the entry for sw_vpn_i |
| sw_fill_i | input | 1 | Install or rewrite the entry for sw_vpn_i |
| sw_retune_i | input | 1 | Rewrite only the permission flags for sw_vpn_i |
| sw_vpn_i | input | 20 | Virtual page number for commands |
| sw_pfn_i | input | 20 | Physical frame number for fills |
| sw_rd_i | input | 1 | Read permission flag for fill or retune |
| sw_wr_i | input | 1 | Write permission flag for fill or retune |

## Verification
The bench fills all eight slots, giving each slot a different mix of permission flags. It then tries loads and stores on every slot, so every pairing of access type and permission is seen. A design that checked the wrong flag, or that let a miss turn into a fault, would show the wrong exception kind or the wrong low code bits. The bench also rewrites a held page before filling new ones, which exposes a design that allocates a duplicate slot or moves the rotation pointer on a rewrite: the wrong older page would then be evicted. Retuning a page that is not held, dropping a single page and idle cycles after an exception are all checked at the ports. These catch a design that retunes a stray slot, drops the wrong entry, or lets the captured address drift.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

  // Access kind code placed in the low bits of the captured faulting address.
  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10
  } acc_code_e;

  // Maintenance command selected for this cycle, after priority resolution.
  typedef enum logic [2:0] {
    SW_IDLE,
    SW_FLUSH,
    SW_DROP,
    SW_FILL,
    SW_RETUNE
  } sw_op_e;

endpackage

// File: rtl/dtlb_entry_array.sv
module dtlb_entry_array #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                            clk_i,
  input  logic                            rst_i,
  input  logic                            flush_i,
  input  logic                            drop_en_i,
  input  logic [IDX_W-1:0]                drop_idx_i,
  input  logic                            fill_en_i,
  input  logic [IDX_W-1:0]                fill_idx_i,
  input  logic [VPN_W-1:0]                fill_vpn_i,
  input  logic [PFN_W-1:0]                fill_pfn_i,
  input  logic                            fill_rd_i,
  input  logic                            fill_wr_i,
  input  logic                            perm_en_i,
  input  logic [IDX_W-1:0]                perm_idx_i,
  input  logic                            perm_rd_i,
  input  logic                            perm_wr_i,
  output logic [ENTRIES-1:0]              valid_o,
  output logic [ENTRIES-1:0][VPN_W-1:0]   tag_o,
  output logic [ENTRIES-1:0][PFN_W-1:0]   pfn_o,
  output logic [ENTRIES-1:0]              rd_o,
  output logic [ENTRIES-1:0]              wr_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic             v_q;
    logic             r_q;
    logic             w_q;
    logic [VPN_W-1:0] tag_q;
    logic [PFN_W-1:0] pfn_q;
    logic             hit_fill;
    logic             hit_drop;
    logic             hit_perm;

    assign hit_fill = fill_en_i && (fill_idx_i == IDX_W'(g));
    assign hit_drop = drop_en_i && (drop_idx_i == IDX_W'(g));
    assign hit_perm = perm_en_i && (perm_idx_i == IDX_W'(g));

    // Control bits carry a reset; flush and drop win over writes.
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        v_q <= 1'b0;
        r_q <= 1'b0;
        w_q <= 1'b0;
      end else if (flush_i) begin
        v_q <= 1'b0;
      end else if (hit_drop) begin
        v_q <= 1'b0;
      end else if (hit_fill) begin
        v_q <= 1'b1;
        r_q <= fill_rd_i;
        w_q <= fill_wr_i;
      end else if (hit_perm) begin
        r_q <= perm_rd_i;
        w_q <= perm_wr_i;
      end
    end

    // Tag and frame storage without reset, written only on a fill.
    always_ff @(posedge clk_i) begin
      if (hit_fill) begin
        tag_q <= fill_vpn_i;
        pfn_q <= fill_pfn_i;
      end
    end

    assign valid_o[g] = v_q;
    assign rd_o[g]    = r_q;
    assign wr_o[g]    = w_q;
    assign tag_o[g]   = tag_q;
    assign pfn_o[g]   = pfn_q;
  end

  // R10: a flush leaves no slot valid on the following cycle.
  p_flush_empty_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    flush_i |=> (valid_o == '0));

  // R9: a dropped slot is invalid afterwards.
  p_drop_gone_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (drop_en_i && !flush_i && (drop_idx_i == '0)) |=> !valid_o[0]);

endmodule

// File: rtl/dtlb_match.sv
module dtlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [VPN_W-1:0]               vpn_i,
  input  logic [ENTRIES-1:0]             valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  tag_i,
  output logic                           hit_o,
  output logic [IDX_W-1:0]               idx_o,
  output logic [ENTRIES-1:0]             hit_vec_o
);

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      hit_vec_o[i] = valid_i[i] && (tag_i[i] == vpn_i);
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec_o[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec_o;

endmodule

// File: rtl/dtlb_victim.sv
module dtlb_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] slot_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_next;

  if ((ENTRIES & (ENTRIES - 1)) == 0) begin : g_pow2
    assign ptr_next = ptr_q + 1'b1;
  end else begin : g_wrap
    assign ptr_next = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       ptr_q <= '0;
    else if (step_i) ptr_q <= ptr_next;
  end

  assign slot_o = ptr_q;

  // R8: rotation wraps from the last slot to slot 0.
  p_wrap_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && ptr_q == LAST) |=> (slot_o == '0));

  // R8: pointer moves only on a step.
  p_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> $stable(slot_o));

endmodule

// File: rtl/dtlb_core.sv
module dtlb_core
  import dtlb_pkg::*;
#(
  parameter  int VA_W      = 32,
  parameter  int PA_W      = 32,
  parameter  int PAGE_BITS = 12,
  parameter  int ENTRIES   = 8,
  localparam int VPN_W     = VA_W - PAGE_BITS,
  localparam int PFN_W     = PA_W - PAGE_BITS,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             acc_valid_i,
  input  logic             acc_write_i,
  input  logic [VA_W-1:0]  acc_vaddr_i,
  output logic             acc_grant_o,
  output logic [PA_W-1:0]  acc_paddr_o,
  output logic             exc_miss_o,
  output logic             exc_fault_o,
  output logic [VA_W-1:0]  exc_addr_o,
  input  logic             sw_flush_i,
  input  logic             sw_drop_i,
  input  logic             sw_fill_i,
  input  logic             sw_retune_i,
  input  logic [VPN_W-1:0] sw_vpn_i,
  input  logic [PFN_W-1:0] sw_pfn_i,
  input  logic             sw_rd_i,
  input  logic             sw_wr_i
);

  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_tag;
  logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn;
  logic [ENTRIES-1:0]             ent_rd;
  logic [ENTRIES-1:0]             ent_wr;

  logic                           acc_hit;
  logic [IDX_W-1:0]               acc_idx;
  logic [ENTRIES-1:0]             acc_hit_vec;
  logic                           sw_hit;
  logic [IDX_W-1:0]               sw_idx;
  logic [ENTRIES-1:0]             sw_hit_vec;

  logic [IDX_W-1:0]               victim;
  sw_op_e                         sw_op;
  logic                           flush_en, drop_en, fill_en, perm_en, step_en;
  logic [IDX_W-1:0]               fill_idx;

  logic                           allowed;
  logic                           take_miss, take_fault;
  acc_code_e                      acc_code;
  logic                           miss_q, fault_q;
  logic [VA_W-1:0]                addr_q;

  // ---------------------------------------------------------------------
  // Command decode: flush > drop > fill > retune.
  // ---------------------------------------------------------------------
  always_comb begin
    if (sw_flush_i)       sw_op = SW_FLUSH;
    else if (sw_drop_i)   sw_op = SW_DROP;
    else if (sw_fill_i)   sw_op = SW_FILL;
    else if (sw_retune_i) sw_op = SW_RETUNE;
    else                  sw_op = SW_IDLE;
  end

  always_comb begin
    flush_en = 1'b0;
    drop_en  = 1'b0;
    fill_en  = 1'b0;
    perm_en  = 1'b0;
    step_en  = 1'b0;
    fill_idx = victim;
    unique case (sw_op)
      SW_FLUSH:  flush_en = 1'b1;
      SW_DROP:   drop_en  = sw_hit;
      SW_FILL: begin
        fill_en  = 1'b1;
        fill_idx = sw_hit ? sw_idx : victim;
        step_en  = !sw_hit;
      end
      SW_RETUNE: perm_en  = sw_hit;
      default: ;
    endcase
  end

  // ---------------------------------------------------------------------
  // Storage, matchers and replacement pointer.
  // ---------------------------------------------------------------------
  dtlb_entry_array #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W),
    .IDX_W   (IDX_W)
  ) i_array (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .flush_i    (flush_en),
    .drop_en_i  (drop_en),
    .drop_idx_i (sw_idx),
    .fill_en_i  (fill_en),
    .fill_idx_i (fill_idx),
    .fill_vpn_i (sw_vpn_i),
    .fill_pfn_i (sw_pfn_i),
    .fill_rd_i  (sw_rd_i),
    .fill_wr_i  (sw_wr_i),
    .perm_en_i  (perm_en),
    .perm_idx_i (sw_idx),
    .perm_rd_i  (sw_rd_i),
    .perm_wr_i  (sw_wr_i),
    .valid_o    (ent_valid),
    .tag_o      (ent_tag),
    .pfn_o      (ent_pfn),
    .rd_o       (ent_rd),
    .wr_o       (ent_wr)
  );

  dtlb_match #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .IDX_W   (IDX_W)
  ) i_acc_match (
    .vpn_i     (acc_vaddr_i[VA_W-1:PAGE_BITS]),
    .valid_i   (ent_valid),
    .tag_i     (ent_tag),
    .hit_o     (acc_hit),
    .idx_o     (acc_idx),
    .hit_vec_o (acc_hit_vec)
  );

  dtlb_match #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .IDX_W   (IDX_W)
  ) i_sw_match (
    .vpn_i     (sw_vpn_i),
    .valid_i   (ent_valid),
    .tag_i     (ent_tag),
    .hit_o     (sw_hit),
    .idx_o     (sw_idx),
    .hit_vec_o (sw_hit_vec)
  );

  dtlb_victim #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) i_victim (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .step_i (step_en),
    .slot_o (victim)
  );

  // ---------------------------------------------------------------------
  // Access path: same-cycle grant, registered exception pulses.
  // ---------------------------------------------------------------------
  assign allowed    = acc_write_i ? ent_wr[acc_idx] : ent_rd[acc_idx];
  assign take_miss  = acc_valid_i && !acc_hit;
  assign take_fault = acc_valid_i && acc_hit && !allowed;
  assign acc_code   = acc_write_i ? ACC_WRITE : ACC_READ;

  assign acc_grant_o = acc_valid_i && acc_hit && allowed;
  assign acc_paddr_o = acc_grant_o ? {ent_pfn[acc_idx], acc_vaddr_i[PAGE_BITS-1:0]} : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      miss_q  <= 1'b0;
      fault_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      miss_q  <= take_miss;
      fault_q <= take_fault;
      if (take_miss || take_fault) addr_q <= {acc_vaddr_i[VA_W-1:2], 2'(acc_code)};
    end
  end

  assign exc_miss_o  = miss_q;
  assign exc_fault_o = fault_q;
  assign exc_addr_o  = addr_q;

  // ---------------------------------------------------------------------
  // Checks
  // ---------------------------------------------------------------------
  // R4: the two exception kinds never coincide.
  p_one_kind_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !(exc_miss_o && exc_fault_o));

  // R4: an absent page yields a miss and no fault.
  p_miss_first_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (acc_valid_i && !acc_hit) |=> (exc_miss_o && !exc_fault_o));

  // R1: a granted access raises no exception afterwards.
  p_grant_clean_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    acc_grant_o |=> (!exc_miss_o && !exc_fault_o));

  // R5: captured address carries exactly one access code bit.
  p_code_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (exc_miss_o || exc_fault_o) |-> ($countones(exc_addr_o[1:0]) == 1));

  // R11: an idle cycle leaves no exception and a steady captured address.
  p_idle_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    !acc_valid_i |=> (!exc_miss_o && !exc_fault_o && $stable(exc_addr_o)));

  // R6: fills never create two slots holding the same page.
  p_unique_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(acc_hit_vec) && $onehot0(sw_hit_vec));

endmodule

// File: tb/test_dtlb_core.sv
module test_dtlb_core;

  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, acc_write;
  logic [31:0] acc_vaddr;
  logic        acc_grant;
  logic [31:0] acc_paddr;
  logic        exc_miss, exc_fault;
  logic [31:0] exc_addr;
  logic        sw_flush, sw_drop, sw_fill, sw_retune;
  logic [19:0] sw_vpn, sw_pfn;
  logic        sw_rd, sw_wr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Bench model of the slot contents
  logic [19:0] m_vpn [8];
  logic [19:0] m_pfn [8];
  bit          m_v   [8];
  bit          m_r   [8];
  bit          m_w   [8];
  int          m_ptr;
  logic [31:0] m_addr;

  always #5 clk = ~clk;

  dtlb_core i_dtlb_core (
    .clk_i       (clk),
    .rst_i       (rst),
    .acc_valid_i (acc_valid),
    .acc_write_i (acc_write),
    .acc_vaddr_i (acc_vaddr),
    .acc_grant_o (acc_grant),
    .acc_paddr_o (acc_paddr),
    .exc_miss_o  (exc_miss),
    .exc_fault_o (exc_fault),
    .exc_addr_o  (exc_addr),
    .sw_flush_i  (sw_flush),
    .sw_drop_i   (sw_drop),
    .sw_fill_i   (sw_fill),
    .sw_retune_i (sw_retune),
    .sw_vpn_i    (sw_vpn),
    .sw_pfn_i    (sw_pfn),
    .sw_rd_i     (sw_rd),
    .sw_wr_i     (sw_wr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int find(logic [19:0] vpn);
    for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  // kind: 0 fill, 1 retune, 2 drop, 3 flush
  task automatic cmd(int kind, logic [19:0] vpn, logic [19:0] pfn, bit r, bit w);
    int k;
    @(negedge clk);
    sw_vpn = vpn; sw_pfn = pfn; sw_rd = r; sw_wr = w;
    sw_fill = (kind == 0); sw_retune = (kind == 1);
    sw_drop = (kind == 2); sw_flush  = (kind == 3);
    k = find(vpn);
    case (kind)
      0: begin
        if (k < 0) begin k = m_ptr; m_ptr = (m_ptr + 1) % 8; end
        m_v[k] = 1; m_vpn[k] = vpn; m_pfn[k] = pfn; m_r[k] = r; m_w[k] = w;
      end
      1: if (k >= 0) begin m_r[k] = r; m_w[k] = w; end
      2: if (k >= 0) m_v[k] = 0;
      default: for (int i = 0; i < 8; i++) m_v[i] = 0;
    endcase
    @(negedge clk);
    sw_fill = 0; sw_retune = 0; sw_drop = 0; sw_flush = 0;
  endtask

  // One access; ctx names the requirement that drove the scenario.
  task automatic access(bit w, logic [31:0] va, string ctx);
    int  k;
    bit  ok;
    string tag;
    k  = find(va[31:12]);
    ok = (k >= 0) && (w ? m_w[k] : m_r[k]);
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_vaddr = va;
    #1;
    tag = {ctx, " R1 grant"};
    chk(tag, {31'd0, acc_grant}, {31'd0, ok});
    if (ok) chk({ctx, " R1 paddr"}, acc_paddr, {m_pfn[k], va[11:0]});
    @(negedge clk);
    acc_valid = 0;
    if (k < 0) begin
      chk({ctx, " R4 miss"}, {30'd0, exc_miss, exc_fault}, 32'd2);
    end else if (!ok) begin
      chk({ctx, w ? " R3 wfault" : " R2 rfault"}, {30'd0, exc_miss, exc_fault}, 32'd1);
    end else begin
      chk({ctx, " R1 noexc"}, {30'd0, exc_miss, exc_fault}, 32'd0);
    end
    if (!ok) m_addr = {va[31:2], w ? 2'b10 : 2'b01};
    chk({ctx, " R5 addr"}, exc_addr, m_addr);
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R11 quiet", {30'd0, exc_miss, exc_fault}, 32'd0);
    chk("R11 hold", exc_addr, m_addr);
  endtask

  function automatic logic [19:0] vpn_of(int k);
    return 20'h00010 + 20'(k) * 20'h00111;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; acc_valid = 0; acc_write = 0; acc_vaddr = '0;
    sw_flush = 0; sw_drop = 0; sw_fill = 0; sw_retune = 0;
    sw_vpn = '0; sw_pfn = '0; sw_rd = 0; sw_wr = 0;
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_r[i] = 0; m_w[i] = 0; end
    m_ptr = 0; m_addr = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12: reset state
    chk("R12 grant", {31'd0, acc_grant}, 32'd0);
    chk("R12 exc", {30'd0, exc_miss, exc_fault}, 32'd0);
    chk("R12 addr", exc_addr, 32'd0);
    access(0, {vpn_of(0), 12'h123}, "R12");
    access(1, {vpn_of(1), 12'h456}, "R12");
    idle_check();

    // R6: fill all slots, permission mix = slot index
    for (int k = 0; k < 8; k++)
      cmd(0, vpn_of(k), 20'hA0000 + 20'(k * 13), k[0], k[1]);
    for (int k = 0; k < 8; k++) begin
      access(0, {vpn_of(k), 12'h5A0 | 12'(k)}, "R6");
      access(1, {vpn_of(k), 12'hF0C ^ 12'(k)}, "R6");
    end
    // R4: absent pages miss for both kinds
    for (int k = 8; k < 12; k++) begin
      access(0, {vpn_of(k), 12'h001}, "R4");
      access(1, {vpn_of(k), 12'h002}, "R4");
    end
    idle_check();
    idle_check();

    // R7: retune flags of every slot
    for (int k = 0; k < 8; k++)
      cmd(1, vpn_of(k), 20'hFFFFF, (k + 1) % 2 == 1, ((k + 1) / 2) % 2 == 1);
    cmd(1, vpn_of(20), 20'h0, 1, 1);
    for (int k = 0; k < 8; k++) begin
      access(0, {vpn_of(k), 12'h777}, "R7");
      access(1, {vpn_of(k), 12'h888}, "R7");
    end
    access(0, {vpn_of(20), 12'h010}, "R7");

    // R6: rewrite held page in place, pointer unchanged
    cmd(0, vpn_of(3), 20'h12345, 1, 1);
    access(0, {vpn_of(3), 12'hABC}, "R6");
    access(1, {vpn_of(3), 12'hABD}, "R6");

    // R8: new pages evict in rotation order
    cmd(0, vpn_of(30), 20'h33333, 1, 0);
    cmd(0, vpn_of(31), 20'h44444, 0, 1);
    for (int k = 0; k < 8; k++) access(0, {vpn_of(k), 12'h100}, "R8");
    access(0, {vpn_of(30), 12'h104}, "R8");
    access(1, {vpn_of(30), 12'h108}, "R8");
    access(1, {vpn_of(31), 12'h10C}, "R8");
    for (int j = 0; j < 7; j++) cmd(0, vpn_of(40 + j), 20'h50000 + 20'(j), 1, 1);
    for (int j = 0; j < 7; j++) access(0, {vpn_of(40 + j), 12'h200}, "R8");
    access(0, {vpn_of(30), 12'h204}, "R8");
    access(0, {vpn_of(31), 12'h208}, "R8");

    // R9: drop one page
    cmd(2, vpn_of(42), 20'h0, 0, 0);
    access(0, {vpn_of(42), 12'h300}, "R9");
    access(0, {vpn_of(43), 12'h304}, "R9");
    access(1, {vpn_of(41), 12'h308}, "R9");
    idle_check();

    // R10: flush everything
    cmd(3, 20'h0, 20'h0, 0, 0);
    for (int j = 0; j < 7; j++) access(j % 2 == 1, {vpn_of(40 + j), 12'h400}, "R10");
    access(0, {vpn_of(31), 12'h404}, "R10");
    idle_check();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule